// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory operation into a stream of element addresses, one per cycle. A start pulse captures a base address, a stride, an addressing mode and a run-time length. The block then issues addresses for elements 0, 1, 2 and so on, in ascending order, on a valid/ready output stream. Each address is tagged with its element number. Three addressing patterns share the one sequencer:

- **Contiguous:** element `i` sits at base plus `i` times the 8-byte element size.
- **Strided:** element `i` sits at base plus `i` times a signed stride.
- **Index-vector:** element `i` sits at base plus the `i`-th signed offset taken from an incoming index stream. Gather loads and scatter stores both use this pattern.

A one-cycle completion flag follows the last accepted address.

Back-pressure works as follows. A downstream memory stage that holds `addr_ready` low freezes the stream. The address and element number stay unchanged until the transfer completes. In index-vector mode the index stream is coupled straight through to the address stream: one index is consumed exactly when one address is accepted, so no index storage is needed. Both streams obey the usual rule: a source that raises valid keeps it and its data until ready is seen. Memory access, data movement and the register file lie outside this block.

Top module: `vec_addr_gen`

## Requirements
- R1: On `start` while idle, the block captures `vlen` and issues exactly min(`vlen`, 64) addresses, with element numbers 0 to n-1 in ascending order. A length above 64 is clamped to 64. `busy` is high from the cycle after start until the cycle the completion flag rises.
- R2: With `mode` = 2'b00, and also with 2'b11, element `i` has address `base + 8*i`, modulo 2^AW.
- R3: With `mode` = 2'b01, element `i` has address `base + i*stride`, where `stride` is two's complement and the result wraps modulo 2^AW.
- R4: With `mode` = 2'b10, `addr_valid` follows `idx_valid` while busy, and `addr = base + idx_data` with `idx_data` signed. `idx_ready` equals `addr_ready` while busy in this mode and is low otherwise. Exactly one index is consumed per accepted address.
- R5: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `addr` and `elem` hold their values into the next cycle. For index-vector mode this holds provided the index source also holds.
- R6: `done` is high for exactly the one cycle after the final address is accepted. `busy` is low in that cycle. `addr_valid`, `idx_ready` and `done` are low after reset.
- R7: A start with length 0 raises `done` in the next cycle and issues no address.
- R8: A start pulse while busy is ignored: the running operation keeps its base, stride, mode and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| mode | input | 2 | 00/11 contiguous, 01 strided, 10 index-vector |
| base | input | AW | Base byte address |
| stride | input | AW | Signed byte stride |
| vlen | input | LENW | Requested element count |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | AW | Signed byte offset for the current element |
| idx_ready | output | 1 | Index consumed this cycle when high with idx_valid |
| addr_valid | output | 1 | Address stream valid |
| addr_ready | input | 1 | Downstream accepts the address |
| addr | output | AW | Element byte address |
| elem | output | EW | Element number of `addr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The embedded assertions check four properties on every cycle:

- the element counter stays below the captured length;
- the counter steps by one per accepted address;
- a stalled strided address holds steady;
- the completion flag follows the final acceptance, and a zero-length start completes at once.

Only the bench scenarios can show the address arithmetic in each mode. These include negative strides, negative indices and wraparound. The scenarios also cover clamping of long lengths, coupling of the index stream under random gaps and stalls, and that a start arriving mid-operation leaves the address sequence untouched.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    VM_UNIT     = 2'b00,
    VM_STRIDE   = 2'b01,
    VM_INDEX    = 2'b10,
    VM_UNIT_ALT = 2'b11
  } vmode_e;
endpackage

// File: rtl/vag_elem_ctr.sv
module vag_elem_ctr #(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len_in,
  input  logic          step,
  output logic          busy,
  output logic [LW-1:0] cnt,
  output logic          last,
  output logic          done
);
  logic [LW-1:0] n_q;

  assign last = busy && (cnt == n_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      n_q  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (step) begin
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (load) begin
        cnt <= '0;
        n_q <= len_in;
        if (len_in == '0) done <= 1'b1;
        else              busy <= 1'b1;
      end
    end
  end

  assert_elem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < n_q));

  assert_elem_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (done && !busy));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load && len_in == '0) |=> (done && !busy));
endmodule

// File: rtl/vag_offset_gen.sv
module vag_offset_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic [AW-1:0] step_val,
  output logic [AW-1:0] offset
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     offset <= '0;
    else if (clear) offset <= '0;
    else if (adv)   offset <= offset + step_val;
  end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAXVL  = 64,
  parameter int EBYTES = 8,
  parameter int LENW   = 8,
  localparam int LW    = $clog2(MAXVL + 1),
  localparam int EW    = $clog2(MAXVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [LENW-1:0] vlen,
  input  logic            idx_valid,
  input  logic [AW-1:0]   idx_data,
  output logic            idx_ready,
  output logic            addr_valid,
  input  logic            addr_ready,
  output logic [AW-1:0]   addr,
  output logic [EW-1:0]   elem,
  output logic            busy,
  output logic            done
);
  logic [AW-1:0] base_q, stride_q, offset, step_val;
  vmode_e        mode_q;
  logic [LW-1:0] len_c, cnt;
  logic          start_acc, is_idx, fire, last;

  assign start_acc = start && !busy;
  assign len_c     = (vlen > LENW'(MAXVL)) ? LW'(MAXVL) : LW'(vlen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      mode_q   <= VM_UNIT;
    end else if (start_acc) begin
      base_q   <= base;
      stride_q <= stride;
      mode_q   <= vmode_e'(mode);
    end
  end

  assign is_idx     = (mode_q == VM_INDEX);
  assign step_val   = (mode_q == VM_STRIDE) ? stride_q : AW'(EBYTES);
  assign addr_valid = busy && (!is_idx || idx_valid);
  assign idx_ready  = busy && is_idx && addr_ready;
  assign fire       = addr_valid && addr_ready;
  assign addr       = base_q + (is_idx ? idx_data : offset);
  assign elem       = cnt[EW-1:0];

  vag_elem_ctr #(.LW(LW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .len_in(len_c),
    .step(fire), .busy(busy), .cnt(cnt), .last(last), .done(done)
  );

  vag_offset_gen #(.AW(AW)) u_off (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .adv(fire && !is_idx),
    .step_val(step_val), .offset(offset)
  );

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !is_idx) |=>
      (addr_valid && $stable(addr) && $stable(elem)));

  assert_valid_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid || idx_ready) |-> busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> ($stable(base_q) && $stable(stride_q) && $stable(mode_q)));
endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] base = '0, stride = '0, idx_data = '0;
  logic [7:0]  vlen = '0;
  logic        idx_valid = 1'b0, addr_ready = 1'b1;
  logic        idx_ready, addr_valid, busy, done;
  logic [31:0] addr;
  logic [5:0]  elem;

  vec_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .idx_valid(idx_valid), .idx_data(idx_data),
    .idx_ready(idx_ready), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr(addr), .elem(elem), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_busy = 0, m_done = 0;
  int          m_i = 0, m_n = 0, m_mode = 0;
  logic [31:0] m_base = '0, m_stride = '0;
  int          issued = 0;

  function automatic bit m_valid();
    return m_busy && (m_mode != 2 || idx_valid);
  endfunction

  function automatic logic [31:0] m_addr();
    if (m_mode == 2) return m_base + idx_data;
    if (m_mode == 1) return m_base + 32'(m_i) * m_stride;
    return m_base + 32'(m_i) * 32'd8;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (addr_valid && addr_ready) issued++;
      m_done = 0;
      if (m_busy) begin
        if (m_valid() && addr_ready) begin
          m_i++;
          if (m_i == m_n) begin m_busy = 0; m_done = 1; end
        end
      end else if (start) begin
        m_n = (vlen > 64) ? 64 : int'(vlen);
        m_mode = int'(mode); m_base = base; m_stride = stride; m_i = 0;
        if (m_n == 0) m_done = 1; else m_busy = 1;
      end
    end
  end

  // per-cycle comparison away from the edge
  logic [31:0] prev_addr; logic [5:0] prev_elem; bit prev_stall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      string at;
      at = (m_mode == 2) ? "R4 addr" : (m_mode == 1) ? "R3 addr" : "R2 addr";
      chk(addr_valid == m_valid(), (m_mode == 2) ? "R4 valid" : "R1 valid", 32'(addr_valid), 32'(m_valid()));
      chk(idx_ready == (m_busy && m_mode == 2 && addr_ready), "R4 idx_ready", 32'(idx_ready), 32'(m_busy && m_mode == 2 && addr_ready));
      chk(done == m_done, (m_n == 0) ? "R7 done" : "R6 done", 32'(done), 32'(m_done));
      chk(busy == m_busy, "R1 busy", 32'(busy), 32'(m_busy));
      if (m_valid()) begin
        chk(addr == m_addr(), at, addr, m_addr());
        chk(elem == 6'(m_i), "R1 elem", 32'(elem), 32'(m_i));
      end
      if (prev_stall && m_mode != 2) begin
        chk(addr_valid && addr == prev_addr && elem == prev_elem, "R5 hold", addr, prev_addr);
      end
      prev_stall = addr_valid && !addr_ready;
      prev_addr = addr; prev_elem = elem;
    end
  end

  // stimulus drivers
  bit          rdy_rand = 0, idx_rand = 0;
  logic [31:0] iv [64];
  int          iptr = 0, icnt = 0;

  always @(posedge clk) begin
    bit f;
    f = idx_valid && idx_ready;
    #1;
    addr_ready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;
    if (f) iptr++;
    begin
      bit held;
      held = idx_valid && !f;
      idx_valid = (iptr < icnt) && (held || !idx_rand || ($urandom % 2 == 1));
      idx_data = (iptr < 64) ? iv[iptr] : '0;
    end
  end

  task automatic run_op(input int md, input logic [31:0] b, input logic [31:0] s,
                        input int len, input bit rr, input int inject_at);
    int expn;
    expn = (len > 64) ? 64 : len;
    rdy_rand = rr;
    iptr = 0;
    icnt = (md == 2) ? expn : 0;
    issued = 0;
    @(posedge clk); #2;
    start = 1; mode = 2'(md); base = b; stride = s; vlen = 8'(len);
    @(posedge clk); #2;
    start = 0;
    if (inject_at > 0) begin
      repeat (inject_at) @(posedge clk);
      #2;
      // R8: a start while busy must leave the running operation untouched
      start = 1; mode = 2'b01; base = 32'hDEAD0000; stride = 32'd4; vlen = 8'd3;
      @(posedge clk); #2;
      start = 0;
    end
    do @(negedge clk); while (m_busy || m_done);
    chk(issued == expn, (inject_at > 0) ? "R8 count" : "R1 count", 32'(issued), 32'(expn));
    rdy_rand = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) iv[k] = 32'((k * 37) % 200) - 32'd64;
    repeat (3) @(posedge clk);
    #3;
    chk(!addr_valid && !done && !idx_ready && !busy, "R6 reset", 32'(addr_valid), 0);
    rst_n = 1;
    run_op(0, 32'h1000, 32'd0, 5, 0, 0);            // R2 contiguous
    run_op(1, 32'h2000, 32'd24, 4, 1, 0);           // R3 stride with stalls, R5
    run_op(1, 32'h100, -32'sd16, 20, 1, 0);         // R3 negative stride, wraps
    idx_rand = 1;
    run_op(2, 32'h8000, 32'd0, 8, 1, 0);            // R4 indexed with gaps
    run_op(2, 32'h40, 32'd0, 64, 0, 0);             // R4 full length
    idx_rand = 0;
    run_op(0, 32'h0, 32'd0, 0, 0, 0);               // R7 zero length
    run_op(2, 32'h0, 32'd0, 0, 0, 0);               // R7 zero length, indexed
    run_op(0, 32'hFFFF_FFC0, 32'd0, 70, 1, 0);      // R1 clamp to 64, wraps
    run_op(3, 32'h3000, 32'd0, 6, 0, 0);            // R2 alternate encoding
    run_op(1, 32'h5000, 32'd12, 10, 0, 3);          // R8 start while busy
    run_op(2, 32'h6000, 32'd0, 9, 1, 2);            // R8 indexed
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule